// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block sits in the fetch stage of a core whose instructions are 16, 32, 48 or 64 bits long. It looks at the leading byte of the first 16-bit instruction word at the fetch address. From that byte it reports the size of the instruction, or of the two-lane parallel bundle that the word starts, and it computes the next program counter. The length is known in the same cycle the word arrives. The fetch unit can therefore issue the next address without waiting out the one-cycle latency of instruction memory. The block is purely combinational and has no state.

A profile input picks one of two length tables. The full table tells scalar forms apart from forms that mark the start of a parallel bundle, and it supports 48-bit instructions. The reduced table knows only 16-bit and 32-bit sizes. In the reduced table, 48-bit forms are flagged illegal and bundle marking is ignored. A bundle-enable input lets a wide core run bundle-marked words as ordinary scalar 32-bit instructions. A build parameter removes bundle support altogether.

Top module: `ild_len_decode`

## Requirements
- R1: With i_lite=0, a leading byte whose top bit is 0, whose top two bits are 10, or whose top three bits are 110 gives o_len=0 (16-bit), o_bundle=0 and o_illegal=0.
- R2: With i_lite=0, leading bytes 1110_0xxx and 1110_10xx give o_len=1 (32-bit) and o_bundle=0, whatever the value of i_bundle_en.
- R3: With i_lite=0, leading bytes 1111_00xx and 1111_100x give o_len=1 (32-bit) and o_bundle=0, whatever the value of i_bundle_en.
- R4: With i_lite=0 and i_bundle_en=1, leading bytes 1111_01xx and 1111_101x give o_len=3 (64-bit) and o_bundle=1.
- R5: With i_lite=0 and i_bundle_en=0, leading bytes 1111_01xx and 1111_101x give o_len=1 (32-bit) and o_bundle=0.
- R6: With i_lite=0, a leading byte 111x_11xx gives o_len=2 (48-bit) and o_illegal=0, whatever the value of i_bundle_en.
- R7: With i_lite=1, leading bytes beginning 0, 10 or 110 give o_len=0. Any other leading byte beginning 111, except the 111x_11xx forms, gives o_len=1. o_bundle is always 0 in this profile.
- R8: With i_lite=1, a leading byte 111x_11xx gives o_illegal=1 and o_len=0, so the PC advances by 2 bytes.
- R9: o_next_pc equals i_pc plus 2, 4, 6 or 8 for o_len codes 0, 1, 2 and 3, taken modulo 2^PC_W.
- R10: The outputs depend only on the top eight bits of i_word. The low eight bits have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_word | input | WORD_W (16) | First instruction word at the fetch address |
| i_pc | input | PC_W (32) | Byte address of that word |
| i_lite | input | 1 | 1 selects the reduced profile, 0 selects the full profile |
| i_bundle_en | input | 1 | 1 lets bundle-marked forms start a two-lane bundle |
| o_len | output | 2 | Length code: 0=16, 1=32, 2=48, 3=64 bits |
| o_bundle | output | 1 | Word starts a two-lane parallel bundle |
| o_illegal | output | 1 | Encoding not allowed in the selected profile |
| o_next_pc | output | PC_W (32) | Address of the following instruction |

## Verification
There are no registers in this block, so every result is due in the same cycle as its stimulus, after the combinational logic settles. The bench changes inputs on the falling clock edge. It then waits one time unit and compares all four outputs, so each sample is taken well away from any rising edge. The reset check, the low-byte sweep and the PC wrap check all follow the same drive-then-settle order.

// File: rtl/ild_pkg.sv
package ild_pkg;
   typedef enum logic [1:0] {
      LEN16 = 2'd0,
      LEN32 = 2'd1,
      LEN48 = 2'd2,
      LEN64 = 2'd3
   } ild_len_e;

   localparam int unsigned ILD_PREFIX_W = 8;
endpackage

// File: rtl/ild_full_table.sv
module ild_full_table
   import ild_pkg::*;
#(
   parameter int unsigned PREFIX_W = 8
) (
   input  logic [PREFIX_W-1:0] i_pfx,
   input  logic                i_bundle_en,
   output ild_len_e            o_len,
   output logic                o_bundle
);
   generate
      if (PREFIX_W != ILD_PREFIX_W) begin : g_bad_pfx
         $error("ild_full_table: prefix width must be eight bits");
      end
   endgenerate

   always_comb begin
      o_len    = LEN16;
      o_bundle = 1'b0;
      casez (i_pfx)
         8'b0???_????,
         8'b10??_????,
         8'b110?_????: o_len = LEN16;
         8'b111?_11??: o_len = LEN48;
         8'b1110_0???,
         8'b1110_10??: o_len = LEN32;
         8'b1111_00??,
         8'b1111_100?: o_len = LEN32;
         8'b1111_01??,
         8'b1111_101?: begin
            if (i_bundle_en) begin
               o_len    = LEN64;
               o_bundle = 1'b1;
            end else begin
               o_len    = LEN32;
            end
         end
         default: o_len = LEN16;
      endcase
   end
endmodule

// File: rtl/ild_lite_table.sv
module ild_lite_table
   import ild_pkg::*;
#(
   parameter int unsigned PREFIX_W = 8
) (
   input  logic [PREFIX_W-1:0] i_pfx,
   output ild_len_e            o_len,
   output logic                o_illegal
);
   generate
      if (PREFIX_W != ILD_PREFIX_W) begin : g_bad_pfx
         $error("ild_lite_table: prefix width must be eight bits");
      end
   endgenerate

   always_comb begin
      o_len     = LEN32;
      o_illegal = 1'b0;
      casez (i_pfx)
         8'b0???_????,
         8'b10??_????,
         8'b110?_????: o_len = LEN16;
         8'b111?_11??: begin
            o_len     = LEN16;
            o_illegal = 1'b1;
         end
         default: o_len = LEN32;
      endcase
   end
endmodule

// File: rtl/ild_pc_step.sv
module ild_pc_step
   import ild_pkg::*;
#(
   parameter int unsigned PC_W = 32
) (
   input  logic [PC_W-1:0] i_pc,
   input  ild_len_e        i_len,
   output logic [PC_W-1:0] o_next_pc
);
   localparam int unsigned STEP_W = 4;

   generate
      if (PC_W < STEP_W) begin : g_bad_pc
         $error("ild_pc_step: PC width must be at least four bits");
      end
   endgenerate

   logic [STEP_W-1:0] step_bytes;

   always_comb begin
      step_bytes = {1'b0, ({1'b0, i_len} + 3'd1), 1'b0} >> 1;
      step_bytes = {step_bytes[STEP_W-2:0], 1'b0};
      o_next_pc  = i_pc + {{(PC_W-STEP_W){1'b0}}, step_bytes};
   end

   always_comb begin
      AST_STEP_KEEPS_ALIGN: assert (o_next_pc[0] == i_pc[0])
         else $error("next PC changed halfword alignment"); // R9
   end
endmodule

// File: rtl/ild_len_decode.sv
module ild_len_decode
   import ild_pkg::*;
#(
   parameter int unsigned PC_W     = 32,
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned PREFIX_W = 8,
   parameter bit          WIDE_EN  = 1'b1
) (
   input  logic [WORD_W-1:0] i_word,
   input  logic [PC_W-1:0]   i_pc,
   input  logic              i_lite,
   input  logic              i_bundle_en,
   output logic [1:0]        o_len,
   output logic              o_bundle,
   output logic              o_illegal,
   output logic [PC_W-1:0]   o_next_pc
);
   localparam int unsigned PFX_LSB = WORD_W - PREFIX_W;

   generate
      if (WORD_W < PREFIX_W) begin : g_bad_word
         $error("ild_len_decode: word narrower than prefix");
      end
      if (PREFIX_W != ILD_PREFIX_W) begin : g_bad_pfx
         $error("ild_len_decode: prefix width must be eight bits");
      end
   endgenerate

   logic [PREFIX_W-1:0] pfx;
   logic                bundle_ok;
   ild_len_e            full_len;
   logic                full_bundle;
   ild_len_e            lite_len;
   logic                lite_illegal;
   ild_len_e            sel_len;

   assign pfx = i_word[WORD_W-1:PFX_LSB];

   generate
      if (WIDE_EN) begin : g_wide
         assign bundle_ok = i_bundle_en;
      end else begin : g_narrow
         assign bundle_ok = 1'b0;
      end
   endgenerate

   ild_full_table #(.PREFIX_W(PREFIX_W)) u_full (
      .i_pfx       (pfx),
      .i_bundle_en (bundle_ok),
      .o_len       (full_len),
      .o_bundle    (full_bundle)
   );

   ild_lite_table #(.PREFIX_W(PREFIX_W)) u_lite (
      .i_pfx     (pfx),
      .o_len     (lite_len),
      .o_illegal (lite_illegal)
   );

   always_comb begin
      if (i_lite) begin
         sel_len   = lite_len;
         o_bundle  = 1'b0;
         o_illegal = lite_illegal;
      end else begin
         sel_len   = full_len;
         o_bundle  = full_bundle;
         o_illegal = 1'b0;
      end
   end

   assign o_len = sel_len;

   ild_pc_step #(.PC_W(PC_W)) u_step (
      .i_pc      (i_pc),
      .i_len     (sel_len),
      .o_next_pc (o_next_pc)
   );

   always_comb begin
      AST_BUNDLE_IS_WIDE: assert (!o_bundle || (o_len == LEN64))
         else $error("bundle flag without 64-bit length"); // R4
      AST_BUNDLE_OFF_SCALAR: assert (i_bundle_en || !o_bundle)
         else $error("bundle flag while bundling disabled"); // R5
      AST_LONG_FULL_ONLY: assert (i_lite == 1'b0 || o_len != LEN48)
         else $error("48-bit length in reduced profile"); // R6
      AST_LITE_NO_BUNDLE: assert (!i_lite || !o_bundle)
         else $error("bundle flag in reduced profile"); // R7
      AST_ILLEGAL_SHORT: assert (!o_illegal || (i_lite && o_len == LEN16))
         else $error("illegal word not stepped by one halfword"); // R8
   end
endmodule

// File: tb/test_ild_len_decode.sv
module test_ild_len_decode;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] word;
   logic [31:0] pc;
   logic        lite;
   logic        ben;
   logic [1:0]  len;
   logic        bundle;
   logic        illegal;
   logic [31:0] next_pc;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   ild_len_decode i_ild_len_decode (
      .i_word      (word),
      .i_pc        (pc),
      .i_lite      (lite),
      .i_bundle_en (ben),
      .o_len       (len),
      .o_bundle    (bundle),
      .o_illegal   (illegal),
      .o_next_pc   (next_pc)
   );

   // vector: lite, bundle_en, prefix[7:0], len[1:0], bundle, illegal, requirement[3:0]
   localparam int NVEC = 21;
   localparam logic [NVEC-1:0][17:0] VECS = {
      {1'b0, 1'b1, 8'h00, 2'd0, 1'b0, 1'b0, 4'd1},  // R1
      {1'b0, 1'b1, 8'h7F, 2'd0, 1'b0, 1'b0, 4'd1},  // R1
      {1'b0, 1'b1, 8'hA5, 2'd0, 1'b0, 1'b0, 4'd1},  // R1
      {1'b0, 1'b1, 8'hC3, 2'd0, 1'b0, 1'b0, 4'd1},  // R1
      {1'b0, 1'b1, 8'hE0, 2'd1, 1'b0, 1'b0, 4'd2},  // R2
      {1'b0, 1'b1, 8'hE9, 2'd1, 1'b0, 1'b0, 4'd2},  // R2
      {1'b0, 1'b1, 8'hF2, 2'd1, 1'b0, 1'b0, 4'd3},  // R3
      {1'b0, 1'b1, 8'hF9, 2'd1, 1'b0, 1'b0, 4'd3},  // R3
      {1'b0, 1'b1, 8'hF5, 2'd3, 1'b1, 1'b0, 4'd4},  // R4
      {1'b0, 1'b1, 8'hFB, 2'd3, 1'b1, 1'b0, 4'd4},  // R4
      {1'b0, 1'b0, 8'hF4, 2'd1, 1'b0, 1'b0, 4'd5},  // R5
      {1'b0, 1'b0, 8'hFA, 2'd1, 1'b0, 1'b0, 4'd5},  // R5
      {1'b0, 1'b1, 8'hEC, 2'd2, 1'b0, 1'b0, 4'd6},  // R6
      {1'b0, 1'b1, 8'hFF, 2'd2, 1'b0, 1'b0, 4'd6},  // R6
      {1'b0, 1'b0, 8'hEE, 2'd2, 1'b0, 1'b0, 4'd6},  // R6
      {1'b1, 1'b1, 8'h3C, 2'd0, 1'b0, 1'b0, 4'd7},  // R7
      {1'b1, 1'b1, 8'hDF, 2'd0, 1'b0, 1'b0, 4'd7},  // R7
      {1'b1, 1'b1, 8'hF5, 2'd1, 1'b0, 1'b0, 4'd7},  // R7
      {1'b1, 1'b1, 8'hE3, 2'd1, 1'b0, 1'b0, 4'd7},  // R7
      {1'b1, 1'b1, 8'hEC, 2'd0, 1'b0, 1'b1, 4'd8},  // R8
      {1'b1, 1'b0, 8'hFF, 2'd0, 1'b0, 1'b1, 4'd8}   // R8
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic l, input logic b, input logic [15:0] w,
                        input logic [31:0] p);
      @(negedge clk);
      lite = l;
      ben  = b;
      word = w;
      pc   = p;
      #1;
   endtask

   function automatic logic [31:0] step_of(input logic [1:0] code);
      return 32'd2 * ({30'd0, code} + 32'd1);
   endfunction

   initial begin
      lite = 1'b0;
      ben  = 1'b0;
      word = 16'h0000;
      pc   = 32'h0000_1000;
      repeat (3) @(posedge clk);
      // reset state: zero word decodes as one halfword
      #1;
      check("R1", "len at reset", {30'd0, len}, 32'd0);
      check("R9", "next_pc at reset", next_pc, 32'h0000_1002);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         logic [17:0] v;
         string       rq;
         logic [31:0] base;
         v    = VECS[NVEC-1-i];
         rq   = $sformatf("R%0d", v[3:0]);
         base = 32'h0040_0000 + 32'd16 * i;
         apply(v[17], v[16], {v[15:8], 8'h5A}, base);
         check(rq, "len", {30'd0, len}, {30'd0, v[7:6]});
         check(rq, "bundle", {31'd0, bundle}, {31'd0, v[5]});
         check(rq, "illegal", {31'd0, illegal}, {31'd0, v[4]});
         check("R9", "next_pc", next_pc, base + step_of(v[7:6]));
      end

      // R10: low byte sweep leaves outputs unchanged
      for (int j = 0; j < 4; j++) begin
         logic [7:0] lo;
         lo = 8'(8'h11 * (j * 5 + 1));
         apply(1'b0, 1'b1, {8'hF6, lo}, 32'h0000_2000);
         check("R10", "len low-byte", {30'd0, len}, 32'd3);
         check("R10", "bundle low-byte", {31'd0, bundle}, 32'd1);
         apply(1'b1, 1'b1, {8'h45, lo}, 32'h0000_2000);
         check("R10", "len low-byte lite", {30'd0, len}, 32'd0);
      end

      // R9: wrap at top of address space
      apply(1'b0, 1'b1, 16'hF700, 32'hFFFF_FFFE);
      check("R9", "next_pc wrap 64", next_pc, 32'h0000_0006);
      apply(1'b0, 1'b0, 16'hEF00, 32'hFFFF_FFFC);
      check("R9", "next_pc wrap 48", next_pc, 32'h0000_0002);
      // R8: illegal forces a two-byte step
      apply(1'b1, 1'b1, 16'hFE00, 32'h0000_0100);
      check("R8", "illegal step", next_pc, 32'h0000_0102);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule